// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers characters from an asynchronous serial line. An external generator supplies a one-cycle tick at sixteen times the bit rate. The line passes through a two-flop synchronizer. A falling edge on it is confirmed by a second look half a bit later. Each following bit is then sampled at its centre. The character is 5 to 8 data bits, sent least significant bit first, with an optional even or odd parity bit and one stop bit. Framing, parity and line-break results are stored next to the data in a 16-entry queue. The queue is drained through a valid/ready stream port.

A status vector has six bits: queue level, overrun, framing, parity, break and receive timeout. It is ORed into a single interrupt request. The five event bits are sticky and are cleared through a per-bit clear input. The level bit follows the queue occupancy. Consumers may stall the stream port as long as they like. Back-pressure never stalls reception; characters arriving while the queue is full are dropped and reported as overrun.

Top module: `uart_rx_sampler`

## Requirements
- R1: From idle, a falling edge of the synchronized line starts a tick count, and the line is sampled again at the 8th tick. If it is high there, the start is rejected, nothing is stored and the receiver waits for the next falling edge.
- R2: After a confirmed start, data bits are sampled every 16 ticks. The count is 5, 6, 7 or 8 for `cfg_bits_i` = 0, 1, 2, 3. The first bit received lands in `m_data_o[0]`, and unused upper bits read 0.
- R3: With `cfg_par_en_i` high, one parity bit follows the data. Even parity (`cfg_par_odd_i`=0) expects an even count of ones over data plus parity, and odd parity expects an odd count. A mismatch sets `m_flags_o[1]` of that entry and sticky `stat_o[3]`.
- R4: A stop bit sampled low sets `m_flags_o[0]` of the entry and sticky `stat_o[2]`.
- R5: When every sample of a frame is 0 (data, parity if enabled, and stop), `m_flags_o[2]` and sticky `stat_o[4]` are set, in addition to the framing error.
- R6: Entries leave `m_data_o`/`m_flags_o` in arrival order. An entry is removed on a cycle with `m_valid_o` and `m_ready_i` both high. While `m_valid_o` is high and `m_ready_i` is low, the entry stays unchanged.
- R7: The queue holds 16 entries. A character completed while 16 are held is discarded, the stored entries are unchanged, and sticky `stat_o[1]` is set.
- R8: `stat_o[0]` is high whenever `level_o` is non-zero and at least `cfg_thresh_i`.
- R9: `stat_o[5]` becomes set when all of these hold for 512 consecutive ticks (32 bit times): the queue is non-empty, below `cfg_thresh_i` and not read, and the receiver is idle. A completed character, a read, an empty queue or a start in progress restarts the count.
- R10: A high bit in `int_clr_i` clears the matching sticky bit 1..5 at the next edge; a new event in the same cycle wins over the clear.
- R11: `irq_o` is high exactly when any `stat_o` bit is high.
- R12: After reset, `m_valid_o`, `level_o`, `stat_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| cfg_bits_i | input | 2 | Data bit count minus 5 |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| cfg_thresh_i | input | 5 | Queue level threshold |
| int_clr_i | input | 6 | Per-bit clear of sticky status |
| m_valid_o | output | 1 | Queue entry available |
| m_ready_i | input | 1 | Consumer takes the entry |
| m_data_o | output | 8 | Received character, zero-extended |
| m_flags_o | output | 3 | {break, parity error, framing error} of the entry |
| level_o | output | 5 | Number of stored entries |
| stat_o | output | 6 | {timeout, break, parity, framing, overrun, level} |
| irq_o | output | 1 | OR of all status bits |

## Verification
The assertions assume a tick of one cycle that is at least several clocks apart from the next. They also assume that the format inputs stay constant for the length of a frame, so a completed character always follows a confirmed start. The stimulus meets this by producing a tick every fourth clock. It changes the format, threshold and clear inputs only between frames, and it changes the serial line only on falling clock edges aligned to tick boundaries.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_err_t;

  typedef struct packed {
    rx_err_t    err;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ST_LEVEL = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_FRM   = 2;
  localparam int ST_PAR   = 3;
  localparam int ST_BRK   = 4;
  localparam int ST_TMO   = 5;
  localparam int ST_W     = 6;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_i,
  input  logic      rx_i,
  input  logic [1:0] cfg_bits_i,
  input  logic      par_en_i,
  input  logic      par_odd_i,
  output logic      busy_o,
  output logic      done_o,
  output rx_entry_t entry_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;
  st_t        st;
  logic       rx_q;
  logic [CW-1:0] tcnt;
  logic [2:0] bcnt;
  logic [7:0] shreg;
  logic       all_zero, par_acc, par_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rx_q <= 1'b1; tcnt <= '0; bcnt <= '0; shreg <= '0;
      all_zero <= 1'b0; par_acc <= 1'b0; par_bad <= 1'b0;
      done_o <= 1'b0; entry_o <= '0;
    end else begin
      rx_q   <= rx_i;
      done_o <= 1'b0;
      case (st)
        S_IDLE: if (rx_q && !rx_i) begin st <= S_START; tcnt <= '0; end
        S_START: if (tick_i) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == MID) begin
            if (!rx_i) begin
              st <= S_DATA; tcnt <= '0; bcnt <= '0; shreg <= '0;
              all_zero <= 1'b1; par_acc <= 1'b0; par_bad <= 1'b0;
            end else st <= S_IDLE;
          end
        end
        S_DATA: if (tick_i) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == LAST) begin
            shreg    <= {rx_i, shreg[7:1]};
            all_zero <= all_zero & ~rx_i;
            par_acc  <= par_acc ^ rx_i;
            bcnt     <= bcnt + 1'b1;
            if (bcnt == {1'b1, cfg_bits_i}) st <= par_en_i ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (tick_i) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == LAST) begin
            par_bad  <= par_acc ^ rx_i ^ par_odd_i;
            all_zero <= all_zero & ~rx_i;
            st       <= S_STOP;
          end
        end
        S_STOP: if (tick_i) begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == LAST) begin
            done_o        <= 1'b1;
            entry_o.data  <= shreg >> (2'd3 - cfg_bits_i);
            entry_o.err.frm <= ~rx_i;
            entry_o.err.brk <= all_zero & ~rx_i;
            entry_o.err.par <= par_bad;
            st            <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st != S_IDLE);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [W-1:0]  rd_data_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push, pop;

  assign push = wr_en_i && (level_o != LW'(DEPTH));
  assign pop  = rd_valid_o && rd_ready_i;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; level_o <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      level_o <= level_o + LW'(push) - LW'(pop);
    end
  end

  assign rd_valid_o = (level_o != '0);
  assign rd_data_o  = mem[rptr];
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int OSR      = 16,
  parameter int TMO_BITS = 32,
  localparam int LW      = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16_i,
  input  logic          rx_i,
  input  logic [1:0]    cfg_bits_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  input  logic [LW-1:0] cfg_thresh_i,
  input  logic [ST_W-1:0] int_clr_i,
  output logic          m_valid_o,
  input  logic          m_ready_i,
  output logic [7:0]    m_data_o,
  output logic [2:0]    m_flags_o,
  output logic [LW-1:0] level_o,
  output logic [ST_W-1:0] stat_o,
  output logic          irq_o
);
  localparam int TMO_TICKS = TMO_BITS * OSR;
  localparam int TW        = $clog2(TMO_TICKS);

  logic      rx_s, frm_busy, frm_done, pop, full, tmo_hit, tmo_fired;
  rx_entry_t frm_entry, q_entry;
  logic [TW-1:0]   tmo_cnt;
  logic [ST_W-1:0] ev_set;
  logic [ST_W-1:1] sticky;

  uart_rx_sync #(.STAGES(2), .RESET_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s));

  uart_rx_frame #(.OSR(OSR)) frame_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick16_i), .rx_i(rx_s),
    .cfg_bits_i(cfg_bits_i), .par_en_i(cfg_par_en_i), .par_odd_i(cfg_par_odd_i),
    .busy_o(frm_busy), .done_o(frm_done), .entry_o(frm_entry));

  uart_rx_fifo #(.W($bits(rx_entry_t)), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(frm_done), .wr_data_i(frm_entry),
    .rd_valid_o(m_valid_o), .rd_ready_i(m_ready_i), .rd_data_o(q_entry),
    .level_o(level_o));

  assign m_data_o  = q_entry.data;
  assign m_flags_o = q_entry.err;
  assign pop       = m_valid_o && m_ready_i;
  assign full      = (level_o == LW'(DEPTH));

  // receive-timeout window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_cnt <= '0; tmo_fired <= 1'b0;
    end else if (frm_busy || frm_done || pop || level_o == '0) begin
      tmo_cnt <= '0; tmo_fired <= 1'b0;
    end else if (tick16_i && !tmo_fired) begin
      if (tmo_cnt == TW'(TMO_TICKS - 1)) tmo_fired <= 1'b1;
      else                               tmo_cnt   <= tmo_cnt + 1'b1;
    end
  end

  assign tmo_hit = tick16_i && !tmo_fired && (tmo_cnt == TW'(TMO_TICKS - 1)) &&
                   !frm_busy && !frm_done && !pop && (level_o != '0) &&
                   (level_o < cfg_thresh_i);

  always_comb begin
    ev_set          = '0;
    ev_set[ST_OVR]  = frm_done && full;
    ev_set[ST_FRM]  = frm_done && frm_entry.err.frm;
    ev_set[ST_PAR]  = frm_done && frm_entry.err.par;
    ev_set[ST_BRK]  = frm_done && frm_entry.err.brk;
    ev_set[ST_TMO]  = tmo_hit;
  end

  for (genvar g = 1; g < ST_W; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky[g] <= 1'b0;
      else        sticky[g] <= ev_set[g] | (sticky[g] & ~int_clr_i[g]);
    end
  end

  assign stat_o = {sticky, (level_o != '0) && (level_o >= cfg_thresh_i)};
  assign irq_o  = |stat_o;
endmodule

// File: rtl/uart_rx_sampler_chk.sv
module uart_rx_sampler_chk #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frm_done,
  input logic [LW-1:0] level,
  input logic          m_valid,
  input logic          m_ready,
  input logic [7:0]    m_data,
  input logic [2:0]    m_flags,
  input logic [5:0]    stat
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R7

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && level == LW'(DEPTH)) |=> stat[1]); // R7

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_flags))); // R6

  AST_FRM_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[2]) |-> $past(frm_done)); // R4

  AST_TMO_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[5]) |-> $past(level) != '0); // R9
endmodule

bind uart_rx_sampler uart_rx_sampler_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .level(level_o),
  .m_valid(m_valid_o), .m_ready(m_ready_i), .m_data(m_data_o),
  .m_flags(m_flags_o), .stat(stat_o));

// File: tb/uart_rx_sampler_tb_top.sv
`timescale 1ns/1ps
module uart_rx_sampler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16, rx = 1'b1;
  logic [1:0] cfg_bits = 2'd3;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic [4:0] cfg_thresh = 5'd16;
  logic [5:0] int_clr = '0;
  logic m_valid, m_ready = 1'b0;
  logic [7:0] m_data;
  logic [2:0] m_flags;
  logic [4:0] level;
  logic [5:0] stat;
  logic irq;
  logic [1:0] tdiv = '0;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 1'b1;
  assign tick16 = (tdiv == 2'd0);

  uart_rx_sampler dut_i (
    .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .rx_i(rx),
    .cfg_bits_i(cfg_bits), .cfg_par_en_i(cfg_par_en), .cfg_par_odd_i(cfg_par_odd),
    .cfg_thresh_i(cfg_thresh), .int_clr_i(int_clr),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data), .m_flags_o(m_flags),
    .level_o(level), .stat_o(stat), .irq_o(irq));

  // {bits, par_en, par_odd, data, bad_par, stop, exp_data, exp_flags}
  localparam logic [24:0] VEC [7] = '{
    {2'd3, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 8'hA5, 3'b000},
    {2'd2, 1'b1, 1'b0, 8'h5A, 1'b0, 1'b1, 8'h5A, 3'b000},
    {2'd0, 1'b1, 1'b1, 8'h13, 1'b0, 1'b1, 8'h13, 3'b000},
    {2'd1, 1'b1, 1'b0, 8'h2C, 1'b1, 1'b1, 8'h2C, 3'b010},
    {2'd3, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0, 8'h3C, 3'b001},
    {2'd3, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 3'b101},
    {2'd3, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b1, 8'hFF, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] b, input logic pe, input logic po,
                            input logic [7:0] d, input logic badp, input logic stp);
    logic p;
    p = 1'b0;
    cfg_bits = b; cfg_par_en = pe; cfg_par_odd = po;
    rx = 1'b0; wait_ticks(16);
    for (int i = 0; i < 5 + int'(b); i++) begin
      rx = d[i]; p = p ^ d[i]; wait_ticks(16);
    end
    if (pe) begin rx = p ^ po ^ badp; wait_ticks(16); end
    rx = stp; wait_ticks(16);
    rx = 1'b1; wait_ticks(4);
  endtask

  task automatic pop_one();
    m_ready = 1'b1; @(negedge clk); m_ready = 1'b0; @(negedge clk);
  endtask

  task automatic clear_all();
    int_clr = 6'h3F; @(negedge clk); int_clr = '0; @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12 valid", m_valid, 0); chk("R12 level", level, 0);
    chk("R12 stat", stat, 0);     chk("R12 irq", irq, 0);
    rst_n = 1'b1;
    wait_ticks(4);

    // vector table: R2 R3 R4 R5 R6
    foreach (VEC[k]) begin
      send_frame(VEC[k][24:23], VEC[k][22], VEC[k][21], VEC[k][20:13], VEC[k][12], VEC[k][11]);
      chk("R6 valid", m_valid, 1);
      chk("R2 data", m_data, VEC[k][10:3]);
      chk("R3/R4/R5 flags", m_flags, VEC[k][2:0]);
      pop_one();
    end
    chk("R3 stat par", stat[3], 1);
    chk("R4 stat frm", stat[2], 1);
    chk("R5 stat brk", stat[4], 1);
    chk("R11 irq", irq, 1);
    clear_all();
    chk("R10 cleared", stat, 0);
    chk("R11 irq low", irq, 0);

    // R1 false start: low for 4 ticks only
    cfg_bits = 2'd3; cfg_par_en = 1'b0;
    rx = 1'b0; wait_ticks(4); rx = 1'b1; wait_ticks(200);
    chk("R1 rejected start", m_valid, 0);
    chk("R1 level", level, 0);

    // R6 back-pressure and R8 level
    cfg_thresh = 5'd2;
    send_frame(2'd3, 1'b0, 1'b0, 8'h11, 1'b0, 1'b1);
    chk("R8 below thresh", stat[0], 0);
    send_frame(2'd3, 1'b0, 1'b0, 8'h22, 1'b0, 1'b1);
    chk("R6 stalled head", m_data, 8'h11);
    chk("R8 level bit", stat[0], 1);
    chk("R11 irq level", irq, 1);
    pop_one();
    chk("R6 second entry", m_data, 8'h22);
    chk("R8 dropped", stat[0], 0);
    pop_one();

    // R7 overrun
    cfg_thresh = 5'd16;
    for (int i = 0; i < 17; i++) send_frame(2'd3, 1'b0, 1'b0, 8'(i + 8'h40), 1'b0, 1'b1);
    chk("R7 level full", level, 16);
    chk("R7 overrun", stat[1], 1);
    for (int i = 0; i < 16; i++) begin
      chk("R7 order kept", m_data, 8'(i + 8'h40));
      pop_one();
    end
    chk("R7 empty after", m_valid, 0);
    clear_all();
    chk("R10 overrun cleared", stat[1], 0);

    // R9 receive timeout
    cfg_thresh = 5'd4;
    send_frame(2'd3, 1'b0, 1'b0, 8'h77, 1'b0, 1'b1);
    wait_ticks(396);
    chk("R9 not yet", stat[5], 0);
    wait_ticks(150);
    chk("R9 timeout", stat[5], 1);
    chk("R11 irq tmo", irq, 1);
    clear_all();
    chk("R10 tmo cleared", stat[5], 0);
    chk("R9 entry kept", m_data, 8'h77);
    pop_one();

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule